// File: doc/BRIEF.md
# Serial flash command sequencer

This block drives an 8-bit serial-access flash device directly from its pins: a chip-enable, a write strobe, an output enable, a command/data select line, a serial clock and a split bidirectional byte bus. A host asks for one of four operations with a single request handshake: serial read, program into an erased sector, program-rewrite, or single-sector erase. Each request carries a 16-bit sector number and a byte count.

Once a request is accepted, the sequencer keeps the device enabled and walks the fixed order for that operation. It sends the operation byte and the two sector bytes on write strobes. It then runs the data phase on the serial clock, streaming host bytes in or read bytes out. For program and erase it sends a start byte, then watches bus bit 7 until the device reports ready. It decodes the failure bit that belongs to the operation and, on a failure, sends a clear-status byte before finishing. A poll limit turns a device that never becomes ready into a reported error.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `fl_ce_n`=1, `fl_we_n`=1, `fl_sc`=0, `fl_dq_oe`=0, `done`=0, `rd_valid`=0, `err`=0.
- R2: Every operation begins with three write-strobe bytes sent with `fl_cmd_sel`=1, in this order. The first is the operation byte: `req_op` 0 → 00H (read), 1 → 1FH (program into an erased sector), 2 → 20H (erase), 3 → 11H (rewrite). The second is `req_sector[15:8]` and the third is `req_sector[7:0]`.
- R3: Every write-strobe low pulse and every serial-clock high pulse lasts exactly PULSE cycles, and each is followed by PULSE inactive cycles.
- R4: Serial-clock pulses occur only with `fl_cmd_sel`=0 and only after the third address byte. A program operation takes exactly `req_len`+1 bytes over `wr_valid`/`wr_ready` and puts each one on `fl_dq_o` for one serial-clock pulse, in the order received.
- R5: Program operations send start byte 40H after their data phase, and erase sends B0H right after the address bytes. Both are sent with `fl_cmd_sel`=1, and erase has no serial-clock phase.
- R6: A read returns `req_len`+1 bytes in device order on `rd_data`. Each byte is held with `rd_valid`=1 until a cycle with `rd_ready`=1.
- R7: After the start byte, no strobe is issued until `fl_dq_i[7]` reads 1, and the bus is not driven while `fl_oe_n`=0. With n poll cycles, `done` rises 8·PULSE+n cycles after an erase is accepted. For a program of N bytes supplied without stalls, it rises 9·PULSE+N·(2·PULSE+1)+n cycles after acceptance.
- R8: On ready, a program operation fails only if `fl_dq_i[4]`=1 and an erase fails only if `fl_dq_i[5]`=1. Failures report `err`=1 with `err_code` 1 for a program failure and 2 for an erase failure; success reports `err`=0 and `err_code` 0.
- R9: After a failure the clear-status byte 50H is sent on a write strobe with `fl_cmd_sel`=1 before `done`. This adds 2·PULSE cycles.
- R10: If `fl_dq_i[7]` stays 0 for POLL_MAX poll cycles, the operation ends with `err`=1 and `err_code`=3, and no clear-status byte is sent.
- R11: `fl_ce_n` is 0 whenever `fl_we_n`=0 or `fl_sc`=1 during an operation, and it is 1 in the cycle `done` is high and while idle.
- R12: `req_ready` is 1 only when idle. Request fields that change after acceptance have no effect on the bytes sent.
- R13: `done` is a one-cycle pulse followed by idle. `err` and `err_code` keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | Operation select |
| req_sector | input | 16 | Sector number |
| req_len | input | LEN_W | Data byte count minus one |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data present |
| wr_ready | output | 1 | Program data taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data present |
| rd_ready | input | 1 | Read data taken |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Last operation failed |
| err_code | output | 2 | 1 program fail, 2 erase fail, 3 poll timeout |
| fl_ce_n | output | 1 | Device enable, active low |
| fl_we_n | output | 1 | Command/address write strobe, active low |
| fl_oe_n | output | 1 | Device output enable, active low |
| fl_cmd_sel | output | 1 | High for command/address cycles, low for data cycles |
| fl_sc | output | 1 | Serial data clock |
| fl_dq_o | output | 8 | Bus value driven to the device |
| fl_dq_oe | output | 1 | Bus drive enable |
| fl_dq_i | input | 8 | Bus value from the device |

## Verification
Completion time follows from the strobe count. An erase finishes 8·PULSE plus the number of poll cycles after acceptance, and a program without stalls adds PULSE plus 2·PULSE+1 cycles per byte. A failure adds 2·PULSE more, and a timeout uses POLL_MAX poll cycles. The bench counts clock edges from the acceptance edge and compares the count with these formulas, sampling everything at the falling clock edge. Bytes are captured by a device model on the rising write strobe and the falling serial clock, and both are checked in order against values computed from the sector number and byte index. Stalled streams are run without latency checks.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int PULSE = 2,
  parameter int LEN_W = 12,
  parameter int POLL_MAX = 4096,
  parameter logic [7:0] CLR_CODE = 8'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_sector,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic             fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic             fl_cmd_sel,
  output logic             fl_sc,
  output logic [7:0]       fl_dq_o,
  output logic             fl_dq_oe,
  input  logic [7:0]       fl_dq_i
);
  localparam int TW = $clog2(2*PULSE+1) + 1;
  localparam int PW = $clog2(POLL_MAX+1);
  localparam logic [TW-1:0] T_P    = TW'(PULSE);
  localparam logic [TW-1:0] T_PM1  = TW'(PULSE-1);
  localparam logic [TW-1:0] T_END  = TW'(2*PULSE-1);
  localparam logic [TW-1:0] T_WEND = TW'(2*PULSE);
  localparam logic [PW-1:0] P_LAST = PW'(POLL_MAX-1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_SA1, S_SA2, S_GAP, S_WDAT, S_RDAT, S_START, S_POLL, S_CLR, S_FIN
  } st_t;

  st_t             st;
  logic [TW-1:0]   t;
  logic [1:0]      op;
  logic [15:0]     sec;
  logic [LEN_W-1:0] left;
  logic [7:0]      obuf;
  logic [PW-1:0]   pcnt;
  logic [7:0]      opcode;
  logic            is_rd, is_er, we_st, strobe_end, fail;

  assign is_rd      = (op == 2'b00);
  assign is_er      = (op == 2'b10);
  assign we_st      = st inside {S_CMD, S_SA1, S_SA2, S_START, S_CLR};
  assign strobe_end = (t == T_END);
  assign fail       = is_er ? fl_dq_i[5] : fl_dq_i[4];

  assign req_ready  = (st == S_IDLE);
  assign wr_ready   = (st == S_WDAT) && (t == '0);
  assign done       = (st == S_FIN);
  assign fl_ce_n    = (st == S_IDLE) || (st == S_FIN);
  assign fl_we_n    = !(we_st && (t < T_P));
  assign fl_cmd_sel = we_st;
  assign fl_oe_n    = !((st == S_POLL) || (st == S_RDAT));
  assign fl_dq_oe   = we_st || (st == S_WDAT);
  assign fl_sc      = ((st == S_WDAT) && (t != '0) && (t <= T_P)) ||
                      ((st == S_RDAT) && !rd_valid && (t < T_P));

  always_comb begin
    case (op)
      2'b00:   opcode = 8'h00;
      2'b01:   opcode = 8'h1F;
      2'b10:   opcode = 8'h20;
      default: opcode = 8'h11;
    endcase
    case (st)
      S_CMD:   fl_dq_o = opcode;
      S_SA1:   fl_dq_o = sec[15:8];
      S_SA2:   fl_dq_o = sec[7:0];
      S_START: fl_dq_o = is_er ? 8'hB0 : 8'h40;
      S_CLR:   fl_dq_o = CLR_CODE;
      default: fl_dq_o = obuf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      t        <= '0;
      op       <= '0;
      sec      <= '0;
      left     <= '0;
      obuf     <= '0;
      pcnt     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
      err_code <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op       <= req_op;
          sec      <= req_sector;
          left     <= req_len;
          err      <= 1'b0;
          err_code <= 2'd0;
          t        <= '0;
          st       <= S_CMD;
        end
        S_CMD, S_SA1, S_SA2, S_START, S_CLR: begin
          t <= t + TW'(1);
          if (strobe_end) begin
            t <= '0;
            case (st)
              S_CMD:   st <= S_SA1;
              S_SA1:   st <= S_SA2;
              S_SA2:   st <= is_er ? S_START : S_GAP;
              S_START: begin st <= S_POLL; pcnt <= '0; end
              default: st <= S_FIN;
            endcase
          end
        end
        S_GAP: begin
          t <= t + TW'(1);
          if (t == T_PM1) begin
            t  <= '0;
            st <= is_rd ? S_RDAT : S_WDAT;
          end
        end
        S_WDAT: begin
          if (t == '0) begin
            if (wr_valid) begin
              obuf <= wr_data;
              t    <= TW'(1);
            end
          end else if (t == T_WEND) begin
            t    <= '0;
            left <= left - LEN_W'(1);
            if (left == '0) st <= S_START;
          end else begin
            t <= t + TW'(1);
          end
        end
        S_RDAT: begin
          if (rd_valid) begin
            if (rd_ready) begin
              rd_valid <= 1'b0;
              t        <= '0;
              left     <= left - LEN_W'(1);
              if (left == '0) st <= S_FIN;
            end
          end else begin
            if (t == T_PM1) rd_data <= fl_dq_i;
            if (strobe_end) rd_valid <= 1'b1;
            else            t <= t + TW'(1);
          end
        end
        S_POLL: begin
          if (fl_dq_i[7]) begin
            if (fail) begin
              err      <= 1'b1;
              err_code <= is_er ? 2'd2 : 2'd1;
              t        <= '0;
              st       <= S_CLR;
            end else begin
              st <= S_FIN;
            end
          end else if (pcnt == P_LAST) begin
            err      <= 1'b1;
            err_code <= 2'd3;
            st       <= S_FIN;
          end else begin
            pcnt <= pcnt + PW'(1);
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_cmd_seq_chk #(
  parameter int PULSE = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       fl_ce_n,
  input logic       fl_we_n,
  input logic       fl_sc,
  input logic       fl_cmd_sel,
  input logic       fl_oe_n,
  input logic       fl_dq_oe,
  input logic       wr_ready
);
  int lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lowcnt <= 0;
    else if (!fl_we_n) lowcnt <= lowcnt + 1;
    else              lowcnt <= 0;
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n && !fl_sc));
  p_strobe_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || fl_sc) |-> !fl_ce_n);
  p_sc_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sc |-> !fl_cmd_sel);
  p_wr_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!fl_sc && fl_we_n));
  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (lowcnt == PULSE));
  p_poll_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  p_err_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(err) && $stable(err_code)));
  p_err_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (err_code != 2'd0));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.PULSE(PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err(err), .err_code(err_code), .fl_ce_n(fl_ce_n),
  .fl_we_n(fl_we_n), .fl_sc(fl_sc), .fl_cmd_sel(fl_cmd_sel),
  .fl_oe_n(fl_oe_n), .fl_dq_oe(fl_dq_oe), .wr_ready(wr_ready)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int P  = 2;
  localparam int LW = 4;
  localparam int PM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = '0;
  logic [15:0]   req_sector = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_valid = 1'b0, wr_ready;
  logic [7:0]    rd_data;
  logic          rd_valid, rd_ready = 1'b1;
  logic          done, err;
  logic [1:0]    err_code;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_cmd_sel, fl_sc, fl_dq_oe;
  logic [7:0]    fl_dq_o, fl_dq_i;

  flash_cmd_seq #(.PULSE(P), .LEN_W(LW), .POLL_MAX(PM)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sector(req_sector), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err), .err_code(err_code),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_cmd_sel(fl_cmd_sel), .fl_sc(fl_sc), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [7:0] wpat(input logic [15:0] s, input int i);
    return s[7:0] + 8'(i * 17) + 8'h03;
  endfunction
  function automatic logic [7:0] rpat(input logic [15:0] s, input int i);
    return s[15:8] ^ 8'(i * 29) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] opbyte(input logic [1:0] o);
    case (o)
      2'd0: return 8'h00;
      2'd1: return 8'h1F;
      2'd2: return 8'h20;
      default: return 8'h11;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model
  int wn, dn, ridx, busy_left, busy_init, first_sc_wn, viol, wcnt, scnt;
  bit rd_mode, st_p, st_e;
  logic [15:0] cur_sec;
  logic [8:0] wlog [16];
  logic [7:0] dlog [16];

  assign fl_dq_i = rd_mode ? rpat(cur_sec, ridx) : {busy_left == 0, 1'b0, st_e, st_p, 4'h0};

  always @(posedge fl_we_n) if (fl_ce_n === 1'b0) begin
    if (wn < 16) wlog[wn] = {fl_cmd_sel, fl_dq_o};
    wn++;
    if (wn == 4 && !rd_mode) busy_left = busy_init;
  end

  always @(negedge fl_sc) if (fl_ce_n === 1'b0) begin
    if (first_sc_wn < 0) first_sc_wn = wn;
    if (fl_oe_n) begin
      if (dn < 16) dlog[dn] = fl_dq_o;
      dn++;
    end else ridx++;
  end

  always @(negedge clk) if (rst_n) begin
    if ((!fl_we_n || fl_sc) && fl_ce_n) viol++;
    if (fl_sc && fl_cmd_sel) viol++;
    if (busy_left > 0 && (!fl_we_n || fl_sc)) viol++;
    if (!fl_we_n) wcnt++;
    else begin if (wcnt != 0 && wcnt != P) viol++; wcnt = 0; end
    if (fl_sc) scnt++;
    else begin if (scnt != 0 && scnt != P) viol++; scnt = 0; end
    if (!fl_oe_n && busy_left > 0) busy_left--;
  end

  task automatic run_op(input logic [1:0] op, input logic [15:0] sec, input int nb,
                        input int busy, input bit pf, input bit ef, input bit gaps);
    int cnt, wi, rn, lat, exp_lat, nexp, code, n;
    bit took, ferr, hang;
    logic [7:0] rbuf [16];
    logic [8:0] ex [6];
    wn = 0; dn = 0; ridx = 0; busy_left = 0; busy_init = busy; first_sc_wn = -1;
    viol = 0; st_p = pf; st_e = ef; rd_mode = (op == 2'd0); cur_sec = sec;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready while idle", int'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_sector = sec; req_len = LW'(nb - 1);
    cnt = 0; wi = 0; rn = 0; took = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin req_op = ~op; req_sector = ~sec; end
      if (took) wi++;
      took = 0;
      if ((op == 2'd1 || op == 2'd3) && wi < nb && !(gaps && cnt % 3 == 0)) begin
        wr_valid = 1'b1; wr_data = wpat(sec, wi); took = wr_ready;
      end else wr_valid = 1'b0;
      rd_ready = !gaps || (cnt % 2 == 0);
      if (rd_valid && rd_ready) begin
        if (rn < 16) rbuf[rn] = rd_data;
        rn++;
      end
      if (done || cnt > 2000) break;
    end
    chk(fl_ce_n == 1'b1, "R11", "enable released at done", int'(fl_ce_n), 1);
    req_valid = 1'b0; wr_valid = 1'b0; rd_ready = 1'b1;
    lat  = cnt - 1;
    hang = (busy > PM);
    ferr = !hang && ((op == 2'd2) ? ef : (op != 2'd0 && pf));
    code = hang ? 3 : (ferr ? ((op == 2'd2) ? 2 : 1) : 0);
    if (op == 2'd0) code = 0;
    chk(err == (code != 0) && err_code == 2'(code), (code == 3) ? "R10" : "R8",
        "error result", {err, err_code}, {code != 0, 2'(code)});
    ex[0] = {1'b1, opbyte(op)}; ex[1] = {1'b1, sec[15:8]}; ex[2] = {1'b1, sec[7:0]};
    ex[3] = {1'b1, (op == 2'd2) ? 8'hB0 : 8'h40}; ex[4] = {1'b1, 8'h50}; ex[5] = '0;
    nexp = 3 + ((op != 2'd0) ? 1 : 0) + (ferr ? 1 : 0);
    chk(wn == nexp, ferr ? "R9" : "R5", "strobed byte count", wn, nexp);
    for (int i = 0; i < nexp && i < wn; i++)
      chk(wlog[i] == ex[i], (i < 3) ? "R2/R12" : ((i == 3) ? "R5" : "R9"),
          "strobed byte", int'(wlog[i]), int'(ex[i]));
    if (op == 2'd1 || op == 2'd3) begin
      chk(dn == nb, "R4", "program byte count", dn, nb);
      for (int i = 0; i < nb && i < dn; i++)
        chk(dlog[i] == wpat(sec, i), "R4", "program byte", int'(dlog[i]), int'(wpat(sec, i)));
      chk(first_sc_wn == 3, "R4", "serial clock after address", first_sc_wn, 3);
    end else if (op == 2'd2) begin
      chk(dn == 0 && first_sc_wn == -1, "R5", "erase has no data phase", dn, 0);
    end else begin
      chk(rn == nb, "R6", "read byte count", rn, nb);
      for (int i = 0; i < nb && i < rn; i++)
        chk(rbuf[i] == rpat(sec, i), "R6", "read byte", int'(rbuf[i]), int'(rpat(sec, i)));
      chk(first_sc_wn == 3, "R4", "serial clock after address", first_sc_wn, 3);
    end
    if (op != 2'd0 && !gaps) begin
      n = hang ? PM : ((busy < 1) ? 1 : busy);
      exp_lat = ((op == 2'd2) ? 8*P : 9*P + nb*(2*P + 1)) + n + (ferr ? 2*P : 0);
      chk(lat == exp_lat, ferr ? "R9" : "R7", "cycles to done", lat, exp_lat);
    end
    chk(viol == 0, "R3/R7/R11", "strobe rule violations", viol, 0);
    @(negedge clk);
    chk(!done && req_ready, "R13", "done single pulse", int'(done), 0);
    repeat (2) @(negedge clk);
    chk(err == (code != 0), "R13", "error held while idle", int'(err), int'(code != 0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int nbs [3];
    nbs[0] = 1; nbs[1] = 2; nbs[2] = 5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req_ready, fl_ce_n, fl_we_n, fl_sc, fl_dq_oe, done, rd_valid, err} == 8'b1110_0000,
        "R1", "reset state", {req_ready, fl_ce_n, fl_we_n, fl_sc, fl_dq_oe, done, rd_valid, err},
        8'b1110_0000);
    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 3; k++)
        for (int g = 0; g < 2; g++)
          run_op(2'(op), 16'(op*4096 + nbs[k]*256 + ((op + k) % 4)*37 + g),
                 nbs[k], (op + k + g) % 4, 1'b0, 1'b0, g[0]);
    run_op(2'd1, 16'h1234, 2, 2, 1'b1, 1'b0, 1'b0);
    run_op(2'd3, 16'h4321, 1, 0, 1'b0, 1'b1, 1'b0);
    run_op(2'd3, 16'h6C01, 3, 1, 1'b1, 1'b0, 1'b0);
    run_op(2'd2, 16'hBEEF, 1, 3, 1'b0, 1'b1, 1'b0);
    run_op(2'd2, 16'h0F0F, 1, 1, 1'b1, 1'b0, 1'b0);
    run_op(2'd1, 16'h5555, 1, 100, 1'b0, 1'b0, 1'b0);
    run_op(2'd2, 16'hAAAA, 1, 100, 1'b0, 1'b1, 1'b0);
    run_op(2'd0, 16'h00FF, 4, 0, 1'b0, 1'b0, 1'b1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule